// File: doc/BRIEF.md
# Two-Byte Signed Result Readout Port

This block is the bus side of a converter whose result is a 13-bit two's-complement word. A sequencer hands it each finished result with a one-cycle valid pulse. A host then fetches the result over an 8-bit port using an active-low chip select and an active-low read strobe. It takes two reads: the upper byte comes first, with sign-extension padding, and the lower byte comes second. The block keeps a byte pointer so that it knows which half the next read returns. It also drives an active-low interrupt flag that tells the host a fresh result is waiting.

All inputs are sampled on the rising clock edge, and every output is a register. The data byte and the driver enable appear one cycle after the strobe condition is seen. The data byte is held at zero whenever the drivers are disabled, so external tri-state buffers can use the enable output directly. If a result arrives while a read strobe is active, it is parked and committed once the strobe ends. A byte that is being read never changes under the host.

The sequencer also raises a start pulse whenever a new conversion or calibration begins. That pulse withdraws any pending interrupt.

Top module: `rdp_top`

## Requirements
- R1: `bus_oe` is 1 in the cycle after an edge at which `cs_n` and `rd_n` were both 0, and 0 otherwise. `bus_q` is 0x00 whenever `bus_oe` is 0.
- R2: The first read after a result is committed returns the upper byte. Bits 3..0 hold result bits 11..8, and bits 7..4 each hold the sign (result bit 12).
- R3: The read that follows the upper byte returns result bits 7..0, with bit i of the byte equal to result bit i.
- R4: A read after the lower byte wraps back to the upper byte, so the returned halves alternate upper, lower, upper.
- R5: The pointer advances once per strobe, at the edge where a strobe that had `cs_n` and `rd_n` both low ends. A strobe with `cs_n` high neither drives the bus nor moves the pointer.
- R6: Committing a new result returns the pointer to the upper byte, even when the previous result was only half read.
- R7: `irq_n` is 0 in the cycle after a result is committed.
- R8: `irq_n` returns to 1 in the cycle after a read strobe begins.
- R9: A `op_start` pulse sets `irq_n` to 1 in the next cycle. If `op_start` and a commit fall in the same cycle, the commit wins and `irq_n` goes to 0.
- R10: A result whose `res_valid` pulse lands during an active strobe does not alter the byte being driven. It is committed at the first edge with the strobe inactive, and a newer result still waiting replaces an older one.
- R11: After reset, `bus_oe` is 0, `bus_q` is 0x00, `irq_n` is 1, the stored result is 0 and the pointer selects the upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| res_valid | input | 1 | One-cycle pulse: `res_data` holds a new result |
| res_data | input | 13 | Two's-complement result, bit 12 sign, bit 0 LSB |
| op_start | input | 1 | One-cycle pulse when a conversion or calibration starts |
| bus_q | output | 8 | Byte presented to the host |
| bus_oe | output | 1 | Enable for the external tri-state drivers |
| irq_n | output | 1 | Interrupt flag, active low |

## Verification
The formatting path is exercised with a set of result words:
- zero;
- the largest positive value;
- the most negative value;
- minus one;
- two mixed patterns.

Together these separate a correct sign fill from a zero fill or a shifted nibble, and a correct lower byte from a byte taken off the wrong boundary.

Directed sequences then cover the pointer behaviour: a third read checks the wrap, an abandoned half-read is followed by a new result, and a strobe is issued with the chip deselected. Interrupt priority is probed by placing a start pulse alone and then in the same cycle as a result. A result pulse placed inside a strobe shows whether the driven byte stays intact and whether the parked result lands afterwards.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } half_e;
endpackage

// File: rtl/rdp_strobe.sv
module rdp_strobe (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  output logic rd_act,
  output logic rd_begin,
  output logic rd_end,
  output logic oe_q
);
  logic act_d;

  assign rd_act   = ~cs_n & ~rd_n;
  assign rd_begin = rd_act & ~act_d;
  assign rd_end   = ~rd_act & act_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_d <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      act_d <= rd_act;
      oe_q  <= rd_act;
    end
  end

  AST_OE_ON: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n) |=> oe_q); // R1
  AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |=> !oe_q); // R1
endmodule

// File: rtl/rdp_store.sv
module rdp_store #(
  parameter int RES_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             rd_act,
  output logic [RES_W-1:0] res_q,
  output logic             commit
);
  logic             park_v;
  logic [RES_W-1:0] park_d;
  logic [RES_W-1:0] next_d;

  assign commit = (res_valid | park_v) & ~rd_act;
  assign next_d = res_valid ? res_data : park_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      park_v <= 1'b0;
      park_d <= '0;
      res_q  <= '0;
    end else if (commit) begin
      res_q  <= next_d;
      park_v <= 1'b0;
    end else if (res_valid) begin
      park_v <= 1'b1;
      park_d <= res_data;
    end
  end

  AST_HOLD_DURING_READ: assert property (@(posedge clk) disable iff (rst)
    rd_act |=> $stable(res_q)); // R10
endmodule

// File: rtl/rdp_bytesel.sv
module rdp_bytesel
  import rdp_pkg::*;
#(
  parameter int RES_W = 13,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RES_W-1:0] res_q,
  input  logic             rd_act,
  input  logic             rd_end,
  input  logic             commit,
  output logic [BUS_W-1:0] bus_q
);
  localparam int HI_W  = RES_W - 1 - BUS_W;
  localparam int PAD_W = BUS_W - HI_W;

  half_e            sel;
  logic [BUS_W-1:0] upper_b;
  logic [BUS_W-1:0] lower_b;

  assign upper_b = {{PAD_W{res_q[RES_W-1]}}, res_q[RES_W-2:BUS_W]};
  assign lower_b = res_q[BUS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= HALF_UPPER;
      bus_q <= '0;
    end else begin
      if (commit)
        sel <= HALF_UPPER;
      else if (rd_end)
        sel <= (sel == HALF_UPPER) ? HALF_LOWER : HALF_UPPER;
      bus_q <= rd_act ? ((sel == HALF_UPPER) ? upper_b : lower_b) : '0;
    end
  end

  AST_SEL_STEADY: assert property (@(posedge clk) disable iff (rst)
    rd_act |=> $stable(sel)); // R5
  AST_SEL_HOME: assert property (@(posedge clk) disable iff (rst)
    commit |=> (sel == HALF_UPPER)); // R6
endmodule

// File: rtl/rdp_irq.sv
module rdp_irq (
  input  logic clk,
  input  logic rst,
  input  logic commit,
  input  logic rd_begin,
  input  logic op_start,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst)
      irq_n <= 1'b1;
    else if (commit)
      irq_n <= 1'b0;
    else if (rd_begin || op_start)
      irq_n <= 1'b1;
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    commit |=> !irq_n); // R7
  AST_IRQ_READ_CLR: assert property (@(posedge clk) disable iff (rst)
    (rd_begin && !commit) |=> irq_n); // R8
  AST_IRQ_START_CLR: assert property (@(posedge clk) disable iff (rst)
    (op_start && !commit) |=> irq_n); // R9
endmodule

// File: rtl/rdp_top.sv
module rdp_top #(
  parameter int RES_W = 13,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             op_start,
  output logic [BUS_W-1:0] bus_q,
  output logic             bus_oe,
  output logic             irq_n
);
  logic             rd_act;
  logic             rd_begin;
  logic             rd_end;
  logic             commit;
  logic [RES_W-1:0] res_q;

  rdp_strobe u_strobe (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n),
    .rd_act(rd_act), .rd_begin(rd_begin), .rd_end(rd_end), .oe_q(bus_oe)
  );

  rdp_store #(.RES_W(RES_W)) u_store (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .rd_act(rd_act), .res_q(res_q), .commit(commit)
  );

  rdp_bytesel #(.RES_W(RES_W), .BUS_W(BUS_W)) u_sel (
    .clk(clk), .rst(rst), .res_q(res_q), .rd_act(rd_act),
    .rd_end(rd_end), .commit(commit), .bus_q(bus_q)
  );

  rdp_irq u_irq (
    .clk(clk), .rst(rst), .commit(commit), .rd_begin(rd_begin),
    .op_start(op_start), .irq_n(irq_n)
  );

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_q == '0)); // R1
endmodule

// File: tb/tb_rdp_top.sv
module tb_rdp_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        res_valid = 1'b0;
  logic [12:0] res_data = '0;
  logic        op_start = 1'b0;
  logic [7:0]  bus_q;
  logic        bus_oe;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rdp_top dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n),
    .res_valid(res_valid), .res_data(res_data), .op_start(op_start),
    .bus_q(bus_q), .bus_oe(bus_oe), .irq_n(irq_n)
  );

  // {data[12:0], upper[7:0], lower[7:0]}
  localparam logic [28:0] VEC [6] = '{
    {13'h0000, 8'h00, 8'h00},
    {13'h0FFF, 8'h0F, 8'hFF},
    {13'h1000, 8'hF0, 8'h00},
    {13'h1FFF, 8'hFF, 8'hFF},
    {13'h0ABC, 8'h0A, 8'hBC},
    {13'h1234, 8'hF2, 8'h34}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [12:0] d);
    @(negedge clk);
    res_valid = 1'b1;
    res_data  = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  // one read strobe; returns sampled byte, checks enable and irq clear
  task automatic rd_byte(input string req, output logic [7:0] b);
    @(negedge clk);
    cs_n = 1'b0;
    rd_n = 1'b0;
    @(negedge clk);
    chk("R1 oe during read", {7'd0, bus_oe}, 8'd1);
    chk("R8 irq cleared by read", {7'd0, irq_n}, 8'd1);
    b = bus_q;
    cs_n = 1'b1;
    rd_n = 1'b1;
    @(negedge clk);
    chk({req, " oe off after read"}, {7'd0, bus_oe}, 8'd0);
  endtask

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset oe", {7'd0, bus_oe}, 8'd0);
    chk("R11 reset bus", bus_q, 8'h00);
    chk("R11 reset irq", {7'd0, irq_n}, 8'd1);
    rd_byte("R11", b);
    chk("R11 reset result upper", b, 8'h00);

    push(13'h0155);
    for (int i = 0; i < 6; i++) begin
      push(VEC[i][28:16]);
      chk("R7 irq after commit", {7'd0, irq_n}, 8'd0);
      rd_byte("R2", b);
      chk("R2 upper byte", b, VEC[i][15:8]);
      rd_byte("R3", b);
      chk("R3 lower byte", b, VEC[i][7:0]);
    end

    // R4 wrap on third read
    push(13'h1234);
    rd_byte("R4", b); chk("R4 first", b, 8'hF2);
    rd_byte("R4", b); chk("R4 second", b, 8'h34);
    rd_byte("R4", b); chk("R4 third wraps", b, 8'hF2);

    // R5 deselected strobe has no effect
    push(13'h0ABC);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk("R5 no drive when deselected", {7'd0, bus_oe}, 8'd0);
    chk("R5 irq untouched when deselected", {7'd0, irq_n}, 8'd0);
    rd_n = 1'b1;
    rd_byte("R5", b); chk("R5 pointer not moved", b, 8'h0A);

    // R6 half-read then new result
    push(13'h0FFF);
    rd_byte("R6", b); chk("R6 upper of new result", b, 8'h0F);

    // R9 start pulse alone, then colliding with a result
    push(13'h0001);
    @(negedge clk); op_start = 1'b1;
    @(negedge clk); op_start = 1'b0;
    chk("R9 start clears irq", {7'd0, irq_n}, 8'd1);
    @(negedge clk); op_start = 1'b1; res_valid = 1'b1; res_data = 13'h0002;
    @(negedge clk); op_start = 1'b0; res_valid = 1'b0;
    chk("R9 commit beats start", {7'd0, irq_n}, 8'd0);

    // R10 results arriving mid-strobe
    push(13'h1FFF);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    chk("R10 upper before late result", bus_q, 8'hFF);
    res_valid = 1'b1; res_data = 13'h0777;
    @(negedge clk);
    res_data = 13'h0001;
    @(negedge clk);
    res_valid = 1'b0;
    chk("R10 byte held during strobe", bus_q, 8'hFF);
    chk("R10 irq stays clear during strobe", {7'd0, irq_n}, 8'd1);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    chk("R10 parked result committed", {7'd0, irq_n}, 8'd0);
    rd_byte("R10", b); chk("R10 upper of newest parked", b, 8'h00);
    rd_byte("R10", b); chk("R10 lower of newest parked", b, 8'h01);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule